// File: doc/BRIEF.md
# Boot Overlay and Code Protection Controller

This block sits next to the program-fetch path of a small 8-bit processor. It owns one flag that decides whether a boot memory region replaces the top 4 KB of the 64 KB code space. Software can set or clear that flag through a bit of an auxiliary control register. A reset can also set it, from either of two conditions. The first is a dedicated recovery pin held low. The second is a stored jump-to-loader configuration bit in its programmed state. When either condition holds at reset, the processor's reset vector is moved from the bottom of code space to the start of the boot region.

The same block turns the stored lock configuration into access grants for the programming and test logic. The lock bits are decoded into a protection level with a fixed priority. Each level removes one more hardware access path: first programming, then verifying, then execution from external memory. A build parameter selects the permanently read-protected variant, which ignores the lock bits.

Configuration inputs (the recovery pin, the jump bit and the lock bits) are sampled only while reset is asserted. After reset they are held until the next reset.

Top module: `bootsec_ctrl`

## Requirements
- R1: If `isp_pin` is 0 during a reset cycle, then after that clock edge `boot_en` is 1 and `reset_vector` is F000h.
- R2: If `bljb_cfg` is 0 (programmed) during a reset cycle, then after that clock edge `boot_en` is 1 and `reset_vector` is F000h.
- R3: If `isp_pin` and `bljb_cfg` are both 1 during a reset cycle, then after that clock edge `boot_en` is 0 and `reset_vector` is 0000h.
- R4: While `rst` is 0, changes on `isp_pin`, `bljb_cfg` and `lock_cfg` do not change `boot_en`, `reset_vector` or the three grant outputs.
- R5: With `rst` at 0, a cycle with `aux_wr` at 1 loads bit 5 of `aux_wdata` into `boot_en` at that clock edge; 1 sets the flag and 0 clears it. The other data bits have no effect.
- R6: `fetch_from_boot` is 1 in the same cycle exactly when `boot_en` is 1 and `fetch_addr` is F000h or higher; otherwise it is 0.
- R7: The lock level is decoded from `lock_cfg` (0 = programmed) with priority. Bit 2 at 0 gives level 3. Otherwise bit 1 at 0 gives level 2. Otherwise bit 0 at 0 gives level 1. `lock_cfg` = 111 gives level 0.
- R8: Level 0 grants all three accesses. Level 1 drops `hw_prog_ok`. Level 2 also drops `hw_verify_ok`. Level 3 also drops `ext_exec_ok`.
- R9: With parameter `READ_DISABLED` = 1, every lock code gives level 2 grants: `ext_exec_ok` = 1, `hw_verify_ok` = 0, `hw_prog_ok` = 0.
- R10: An `aux_wr` in a reset cycle has no effect; the reset conditions of R1 to R3 decide `boot_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is sampled while high |
| isp_pin | input | 1 | Recovery pin level; 0 requests boot at reset |
| bljb_cfg | input | 1 | Jump-to-loader configuration bit; 0 means programmed |
| lock_cfg | input | 3 | Lock configuration bits; 0 means programmed |
| aux_wr | input | 1 | Write strobe for the auxiliary control register |
| aux_wdata | input | 8 | Write data; bit 5 is the boot overlay bit |
| fetch_addr | input | 16 | Current code-fetch address |
| boot_en | output | 1 | Boot overlay enabled |
| reset_vector | output | 16 | Address the processor starts from after reset |
| fetch_from_boot | output | 1 | 1 selects boot memory for this fetch, 0 user memory |
| ext_exec_ok | output | 1 | Execution from external memory is granted |
| hw_verify_ok | output | 1 | Hardware verify (read-out) is granted |
| hw_prog_ok | output | 1 | Hardware programming is granted |

## Verification
All results that come from sampled configuration are registered. They are due at the first rising edge at which `rst` is high, and the bench checks them 2 ns after a reset edge or after reset is released. An auxiliary write takes effect at the edge that captures it, so the flag is checked 2 ns after that edge and is dropped before the next one. The fetch select is combinational. It is checked after the address settles within one cycle, with no clock edge between stimulus and sample.

// File: rtl/bootsec_pkg.sv
package bootsec_pkg;

    typedef enum logic [1:0] {
        LVL_OPEN      = 2'd0,
        LVL_NO_PROG   = 2'd1,
        LVL_NO_VERIFY = 2'd2,
        LVL_SEALED    = 2'd3
    } lock_lvl_e;

    typedef struct packed {
        logic ext_exec;
        logic hw_verify;
        logic hw_prog;
    } access_t;

    localparam int LOCK_BITS = 3;

    // Programmed configuration bits read as 0.
    function automatic lock_lvl_e decode_lock(input logic [LOCK_BITS-1:0] cfg_n);
        lock_lvl_e lvl;
        if (!cfg_n[2])      lvl = LVL_SEALED;
        else if (!cfg_n[1]) lvl = LVL_NO_VERIFY;
        else if (!cfg_n[0]) lvl = LVL_NO_PROG;
        else                lvl = LVL_OPEN;
        return lvl;
    endfunction

    function automatic access_t grant_for(input lock_lvl_e lvl);
        access_t g;
        g.ext_exec  = (lvl != LVL_SEALED);
        g.hw_verify = (lvl == LVL_OPEN) || (lvl == LVL_NO_PROG);
        g.hw_prog   = (lvl == LVL_OPEN);
        return g;
    endfunction

endpackage

// File: rtl/bootsec_lock_unit.sv
module bootsec_lock_unit
    import bootsec_pkg::*;
#(
    parameter bit READ_DISABLED = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LOCK_BITS-1:0] lock_cfg,
    output access_t              grants
);
    lock_lvl_e lvl_next;
    access_t   grants_q;

    generate
        if (READ_DISABLED) begin : g_fixed
            assign lvl_next = LVL_NO_VERIFY;
        end else begin : g_decoded
            assign lvl_next = decode_lock(lock_cfg);
        end
    endgenerate

    // Lock state is captured only during reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            grants_q <= grant_for(lvl_next);
        end
    end

    assign grants = grants_q;

endmodule

// File: rtl/bootsec_boot_flag.sv
module bootsec_boot_flag #(
    parameter int                CTRL_W      = 8,
    parameter int                BOOT_BIT    = 5,
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BOOT_VECTOR = 16'hF000,
    parameter logic [ADDR_W-1:0] USER_VECTOR = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              isp_pin,
    input  logic              bljb_cfg,
    input  logic              aux_wr,
    input  logic [CTRL_W-1:0] aux_wdata,
    output logic              boot_en,
    output logic [ADDR_W-1:0] reset_vector
);
    logic boot_req;
    logic flag_q;
    logic [ADDR_W-1:0] vec_q;

    assign boot_req = !isp_pin || !bljb_cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= boot_req;
            vec_q  <= boot_req ? BOOT_VECTOR : USER_VECTOR;
        end else if (aux_wr) begin
            flag_q <= aux_wdata[BOOT_BIT];
        end
    end

    assign boot_en      = flag_q;
    assign reset_vector = vec_q;

endmodule

// File: rtl/bootsec_fetch_map.sv
module bootsec_fetch_map #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000
) (
    input  logic              boot_en,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_from_boot
);
    logic in_window;

    assign in_window       = (fetch_addr >= BOOT_BASE);
    assign fetch_from_boot = boot_en && in_window;

endmodule

// File: rtl/bootsec_ctrl.sv
module bootsec_ctrl
    import bootsec_pkg::*;
#(
    parameter bit                READ_DISABLED = 1'b0,
    parameter int                ADDR_W        = 16,
    parameter int                CTRL_W        = 8,
    parameter int                BOOT_BIT      = 5,
    parameter logic [ADDR_W-1:0] BOOT_BASE     = 16'hF000,
    parameter logic [ADDR_W-1:0] USER_VECTOR   = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              isp_pin,
    input  logic              bljb_cfg,
    input  logic [2:0]        lock_cfg,
    input  logic              aux_wr,
    input  logic [CTRL_W-1:0] aux_wdata,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              boot_en,
    output logic [ADDR_W-1:0] reset_vector,
    output logic              fetch_from_boot,
    output logic              ext_exec_ok,
    output logic              hw_verify_ok,
    output logic              hw_prog_ok
);
    localparam logic [ADDR_W-1:0] BOOT_VECTOR = BOOT_BASE;

    access_t grants;

    bootsec_boot_flag #(
        .CTRL_W     (CTRL_W),
        .BOOT_BIT   (BOOT_BIT),
        .ADDR_W     (ADDR_W),
        .BOOT_VECTOR(BOOT_VECTOR),
        .USER_VECTOR(USER_VECTOR)
    ) u_flag (
        .clk         (clk),
        .rst         (rst),
        .isp_pin     (isp_pin),
        .bljb_cfg    (bljb_cfg),
        .aux_wr      (aux_wr),
        .aux_wdata   (aux_wdata),
        .boot_en     (boot_en),
        .reset_vector(reset_vector)
    );

    bootsec_fetch_map #(
        .ADDR_W   (ADDR_W),
        .BOOT_BASE(BOOT_BASE)
    ) u_map (
        .boot_en        (boot_en),
        .fetch_addr     (fetch_addr),
        .fetch_from_boot(fetch_from_boot)
    );

    bootsec_lock_unit #(
        .READ_DISABLED(READ_DISABLED)
    ) u_lock (
        .clk     (clk),
        .rst     (rst),
        .lock_cfg(lock_cfg),
        .grants  (grants)
    );

    assign ext_exec_ok  = grants.ext_exec;
    assign hw_verify_ok = grants.hw_verify;
    assign hw_prog_ok   = grants.hw_prog;

endmodule

// File: rtl/bootsec_ctrl_sva.sv
module bootsec_ctrl_sva #(
    parameter bit                READ_DISABLED = 1'b0,
    parameter int                ADDR_W        = 16,
    parameter int                CTRL_W        = 8,
    parameter int                BOOT_BIT      = 5,
    parameter logic [ADDR_W-1:0] BOOT_BASE     = 16'hF000,
    parameter logic [ADDR_W-1:0] USER_VECTOR   = 16'h0000
) (
    input logic              clk,
    input logic              rst,
    input logic              isp_pin,
    input logic              bljb_cfg,
    input logic [2:0]        lock_cfg,
    input logic              aux_wr,
    input logic [CTRL_W-1:0] aux_wdata,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              boot_en,
    input logic [ADDR_W-1:0] reset_vector,
    input logic              fetch_from_boot,
    input logic              ext_exec_ok,
    input logic              hw_verify_ok,
    input logic              hw_prog_ok
);
    p_isp_boot_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) && $past(!isp_pin) |-> boot_en && reset_vector == BOOT_BASE);

    p_jump_boot_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) && $past(!bljb_cfg) |-> boot_en && reset_vector == BOOT_BASE);

    // R3, and R10: a write strobe during reset plays no part here
    p_user_start_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) && $past(isp_pin) && $past(bljb_cfg) |-> !boot_en && reset_vector == USER_VECTOR);

    p_flag_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !aux_wr |=> $stable(boot_en));

    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(reset_vector) && $stable(ext_exec_ok) && $stable(hw_verify_ok) && $stable(hw_prog_ok));

    p_aux_load_r5: assert property (@(posedge clk) disable iff (rst)
        aux_wr |=> boot_en == $past(aux_wdata[BOOT_BIT]));

    p_fetch_sel_r6: assert property (@(posedge clk) disable iff (rst)
        fetch_from_boot == (boot_en && fetch_addr >= BOOT_BASE));

    p_grant_order_r8: assert property (@(posedge clk) disable iff (rst)
        (hw_prog_ok |-> hw_verify_ok) and (hw_verify_ok |-> ext_exec_ok));

    generate
        if (READ_DISABLED) begin : g_rd
            p_fixed_level_r9: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> ext_exec_ok && !hw_verify_ok && !hw_prog_ok);
        end else begin : g_lb
            p_top_lock_r7: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> ext_exec_ok == $past(lock_cfg[2]));
            p_mid_lock_r7: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> hw_verify_ok == ($past(lock_cfg[2]) && $past(lock_cfg[1])));
            p_low_lock_r7: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> hw_prog_ok == ($past(lock_cfg) == 3'b111));
        end
    endgenerate

endmodule

bind bootsec_ctrl bootsec_ctrl_sva #(
    .READ_DISABLED(READ_DISABLED),
    .ADDR_W       (ADDR_W),
    .CTRL_W       (CTRL_W),
    .BOOT_BIT     (BOOT_BIT),
    .BOOT_BASE    (BOOT_BASE),
    .USER_VECTOR  (USER_VECTOR)
) u_sva (
    .clk            (clk),
    .rst            (rst),
    .isp_pin        (isp_pin),
    .bljb_cfg       (bljb_cfg),
    .lock_cfg       (lock_cfg),
    .aux_wr         (aux_wr),
    .aux_wdata      (aux_wdata),
    .fetch_addr     (fetch_addr),
    .boot_en        (boot_en),
    .reset_vector   (reset_vector),
    .fetch_from_boot(fetch_from_boot),
    .ext_exec_ok    (ext_exec_ok),
    .hw_verify_ok   (hw_verify_ok),
    .hw_prog_ok     (hw_prog_ok)
);

// File: tb/bootsec_ctrl_test.sv
`timescale 1ns/1ps
module bootsec_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        isp_pin = 1'b1;
    logic        bljb_cfg = 1'b1;
    logic [2:0]  lock_cfg = 3'b111;
    logic        aux_wr = 1'b0;
    logic [7:0]  aux_wdata = 8'h00;
    logic [15:0] fetch_addr = 16'h0000;

    logic        boot_en, fetch_from_boot, ext_ok, ver_ok, prog_ok;
    logic [15:0] reset_vector;
    logic        rd_boot_en, rd_fetch, rd_ext, rd_ver, rd_prog;
    logic [15:0] rd_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bootsec_ctrl uut (
        .clk(clk), .rst(rst), .isp_pin(isp_pin), .bljb_cfg(bljb_cfg),
        .lock_cfg(lock_cfg), .aux_wr(aux_wr), .aux_wdata(aux_wdata),
        .fetch_addr(fetch_addr), .boot_en(boot_en), .reset_vector(reset_vector),
        .fetch_from_boot(fetch_from_boot), .ext_exec_ok(ext_ok),
        .hw_verify_ok(ver_ok), .hw_prog_ok(prog_ok)
    );

    bootsec_ctrl #(.READ_DISABLED(1'b1)) uut_rd (
        .clk(clk), .rst(rst), .isp_pin(isp_pin), .bljb_cfg(bljb_cfg),
        .lock_cfg(lock_cfg), .aux_wr(aux_wr), .aux_wdata(aux_wdata),
        .fetch_addr(fetch_addr), .boot_en(rd_boot_en), .reset_vector(rd_vec),
        .fetch_from_boot(rd_fetch), .ext_exec_ok(rd_ext),
        .hw_verify_ok(rd_ver), .hw_prog_ok(rd_prog)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset(input logic isp, input logic jmp, input logic [2:0] lk);
        rst = 1'b1; isp_pin = isp; bljb_cfg = jmp; lock_cfg = lk;
        step(); step();
        rst = 1'b0;
        step();
    endtask

    function automatic logic [2:0] exp_grants(input logic [2:0] lk);
        // {ext, verify, prog}
        if (lk[2] == 1'b0)      return 3'b000;
        else if (lk[1] == 1'b0) return 3'b100;
        else if (lk[0] == 1'b0) return 3'b110;
        else                    return 3'b111;
    endfunction

    task automatic t_plain_reset();
        do_reset(1'b1, 1'b1, 3'b111);
        check(boot_en == 1'b0, "R3", "boot_en", boot_en, 0);
        check(reset_vector == 16'h0000, "R3", "vector", reset_vector, 16'h0000);
        check({ext_ok, ver_ok, prog_ok} == 3'b111, "R8", "grants lvl0", {ext_ok, ver_ok, prog_ok}, 3'b111);
    endtask

    task automatic t_isp_boot();
        do_reset(1'b0, 1'b1, 3'b111);
        check(boot_en == 1'b1, "R1", "boot_en", boot_en, 1);
        check(reset_vector == 16'hF000, "R1", "vector", reset_vector, 16'hF000);
    endtask

    task automatic t_jump_boot();
        do_reset(1'b1, 1'b0, 3'b111);
        check(boot_en == 1'b1, "R2", "boot_en", boot_en, 1);
        check(reset_vector == 16'hF000, "R2", "vector", reset_vector, 16'hF000);
        do_reset(1'b0, 1'b0, 3'b111);
        check(boot_en == 1'b1 && reset_vector == 16'hF000, "R2", "both requests", reset_vector, 16'hF000);
    endtask

    task automatic t_lock_codes();
        for (int i = 0; i < 8; i++) begin
            logic [2:0] e;
            do_reset(1'b1, 1'b1, 3'(i));
            e = exp_grants(3'(i));
            check({ext_ok, ver_ok, prog_ok} == e, "R7", $sformatf("lock code %0d", i),
                  {ext_ok, ver_ok, prog_ok}, e);
            check({rd_ext, rd_ver, rd_prog} == 3'b100, "R9", $sformatf("read-disabled code %0d", i),
                  {rd_ext, rd_ver, rd_prog}, 3'b100);
        end
        do_reset(1'b1, 1'b1, 3'b110);
        check({ext_ok, ver_ok, prog_ok} == 3'b110, "R8", "lvl1 drops prog", {ext_ok, ver_ok, prog_ok}, 3'b110);
        do_reset(1'b1, 1'b1, 3'b101);
        check({ext_ok, ver_ok, prog_ok} == 3'b100, "R8", "lvl2 drops verify", {ext_ok, ver_ok, prog_ok}, 3'b100);
        do_reset(1'b1, 1'b1, 3'b011);
        check({ext_ok, ver_ok, prog_ok} == 3'b000, "R8", "lvl3 drops ext", {ext_ok, ver_ok, prog_ok}, 3'b000);
    endtask

    task automatic t_sample_only();
        do_reset(1'b1, 1'b1, 3'b111);
        isp_pin = 1'b0; bljb_cfg = 1'b0; lock_cfg = 3'b000;
        step(); step(); step();
        check(boot_en == 1'b0, "R4", "boot_en after pin change", boot_en, 0);
        check(reset_vector == 16'h0000, "R4", "vector after pin change", reset_vector, 0);
        check({ext_ok, ver_ok, prog_ok} == 3'b111, "R4", "grants after lock change",
              {ext_ok, ver_ok, prog_ok}, 3'b111);
        isp_pin = 1'b1; bljb_cfg = 1'b1; lock_cfg = 3'b111;
    endtask

    task automatic t_aux_write();
        do_reset(1'b1, 1'b1, 3'b111);
        aux_wr = 1'b1; aux_wdata = 8'h20;
        step();
        aux_wr = 1'b0; aux_wdata = 8'h00;
        check(boot_en == 1'b1, "R5", "set by write", boot_en, 1);
        step();
        check(boot_en == 1'b1, "R5", "held after write", boot_en, 1);
        aux_wr = 1'b1; aux_wdata = 8'hDF;
        step();
        aux_wr = 1'b0;
        check(boot_en == 1'b0, "R5", "cleared, other bits set", boot_en, 0);
        check(reset_vector == 16'h0000, "R5", "vector untouched", reset_vector, 0);
    endtask

    task automatic t_fetch_map();
        do_reset(1'b1, 1'b1, 3'b111);
        fetch_addr = 16'hF000; #1;
        check(fetch_from_boot == 1'b0, "R6", "flag off F000", fetch_from_boot, 0);
        aux_wr = 1'b1; aux_wdata = 8'h20;
        step();
        aux_wr = 1'b0;
        fetch_addr = 16'hEFFF; #1;
        check(fetch_from_boot == 1'b0, "R6", "EFFF", fetch_from_boot, 0);
        fetch_addr = 16'hF000; #1;
        check(fetch_from_boot == 1'b1, "R6", "F000", fetch_from_boot, 1);
        fetch_addr = 16'hFFFF; #1;
        check(fetch_from_boot == 1'b1, "R6", "FFFF", fetch_from_boot, 1);
        fetch_addr = 16'h0000; #1;
        check(fetch_from_boot == 1'b0, "R6", "0000", fetch_from_boot, 0);
    endtask

    task automatic t_reset_wins();
        rst = 1'b1; isp_pin = 1'b1; bljb_cfg = 1'b1; lock_cfg = 3'b111;
        aux_wr = 1'b1; aux_wdata = 8'h20;
        step(); step();
        aux_wr = 1'b0; rst = 1'b0;
        step();
        check(boot_en == 1'b0, "R10", "write during reset", boot_en, 0);
    endtask

    initial begin
        t_plain_reset();
        t_isp_boot();
        t_jump_boot();
        t_lock_codes();
        t_sample_only();
        t_aux_write();
        t_fetch_map();
        t_reset_wins();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule